// File: doc/BRIEF.md
# Interrupt Entry and Stack Sequencer

This block runs the multi-cycle bus sequences of an 8-bit processor that move the program counter and status through the stack. Six sequences exist: three hardware entries (reset, non-maskable interrupt, maskable interrupt), the software break entry, return-from-interrupt and return-from-subroutine. The surrounding decode logic raises a one-cycle start strobe with a kind code. The sequencer then issues one bus request per clock (read or write, 16-bit address, 8-bit write data), takes read data back in the same cycle, and raises a one-cycle done pulse once the last bus cycle has completed.

The block owns the 8-bit stack pointer, the 16-bit program counter and the interrupt-disable flag. The status byte to push comes in from outside. A status byte pulled by a return goes back out with a one-cycle valid strobe. Two request inputs are turned into pending indications for decode. The maskable request is sampled through a two-stage pipeline that is gated by the disable flag. The non-maskable request is latched until an entry sequence consumes it. A hold input stretches read cycles only.

Top module: `irq_stack_seq`

## Requirements
- R1: Every stack access uses address 0x0100 OR the 8-bit stack pointer. A push uses the current pointer and then decrements it. A pull first increments the pointer and then reads at the new value.
- R2: An entry sequence writes three bytes in order: PC high, PC low, status. The status byte is `status_i` with bit 4 forced to 1 for break and forced to 0 for the hardware interrupts. Break advances PC by one before the PC high byte is pushed.
- R3: After the pushes, an entry reads the vector low byte and then the high byte at vector+1, and loads them into PC. The vector is 0xFFFA for NMI, 0xFFFC for reset and 0xFFFE for IRQ and break. The disable flag `idis_o` is 1 after every entry.
- R4: If `nmi_pend_o` is set when a break entry picks its vector, 0xFFFA is used and the pending flag clears. An NMI entry also clears it. A pulse on `nmi_req_i` sets `nmi_pend_o` on the next clock.
- R5: A reset entry makes its three stack cycles as reads (`bus_wr_o`=0), and the pointer still decrements three times.
- R6: Return-from-interrupt pulls status, then PC low, then PC high. The pulled status appears on `pull_stat_o`, and bit 2 of that status becomes `idis_o`.
- R7: Return-from-subroutine pulls PC low, then PC high, then reads at the pulled PC, and ends with PC one above the pulled value.
- R8: `irq_pend_o` equals (`irq_line_i` AND NOT `idis_o`) as it was two unstalled clocks earlier. While `idis_o`=1, a raised line is never seen as pending.
- R9: While `hold_i`=1, a read cycle repeats with its address, PC and stack pointer unchanged. Write cycles complete regardless of `hold_i`.
- R10: The stack pointer wraps modulo 256 in both directions.
- R11: `done_o` is high for exactly one clock, following the clock on which the last bus cycle completed, and the bus is idle then. A start while a sequence runs, or with kind 6 or 7, is ignored.
- R12: During reset, PC and stack pointer read 0, `idis_o` is 1, and the bus, pending and done outputs are 0.

Kind codes on `seq_kind_i`: 0 reset, 1 NMI, 2 IRQ, 3 break, 4 return-from-interrupt, 5 return-from-subroutine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start_i | input | 1 | Start strobe for a sequence |
| seq_kind_i | input | 3 | Sequence kind code |
| hold_i | input | 1 | Stall request, honoured on read cycles only |
| irq_line_i | input | 1 | Maskable interrupt line |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| status_i | input | 8 | Status byte to push on entry |
| bus_rdata_i | input | 8 | Read data for the current bus cycle |
| bus_act_o | output | 1 | A bus cycle is requested this clock |
| bus_wr_o | output | 1 | The requested cycle is a write |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| idis_o | output | 1 | Interrupt-disable flag |
| irq_pend_o | output | 1 | Maskable interrupt recognised |
| nmi_pend_o | output | 1 | Non-maskable request pending |
| pull_stat_o | output | 8 | Status byte pulled by the last return-from-interrupt |
| pull_vld_o | output | 1 | One-clock strobe when `pull_stat_o` updates |
| done_o | output | 1 | One-clock end-of-sequence pulse |

## Verification
A chained script of eleven sequences is run. The trace starts from a zero stack pointer, so the first reset shows wrap-around. It then pairs each entry kind with a return, which shows whether pushed bytes, the break bit and the pulled disable bit survive a round trip. A break with a latched NMI separates vector takeover from the plain break path, and a prepared stack for return-from-subroutine checks the dummy read and the final increment. Directed runs then apply hold across both write-only and read-only stretches, where the cycle count shows that only reads stall. They also raise the interrupt line with the disable flag set and with it clear, and issue starts while busy and with unused kind codes.

// File: rtl/isq_pkg.sv
package isq_pkg;

  localparam int DW = 8;
  localparam int AW = 16;
  localparam int KW = 3;

  localparam logic [DW-1:0] STK_PAGE = 8'h01;
  localparam int BRK_BIT  = 4;
  localparam int IDIS_BIT = 2;

  typedef enum logic [KW-1:0] {
    K_RST = 3'd0,
    K_NMI = 3'd1,
    K_IRQ = 3'd2,
    K_BRK = 3'd3,
    K_RTI = 3'd4,
    K_RTS = 3'd5
  } seq_kind_e;

  localparam logic [KW-1:0] KIND_MAX = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_VEC_L,
    ST_VEC_H,
    ST_PULL_P,
    ST_PULL_L,
    ST_PULL_H,
    ST_DUMMY
  } seq_step_e;

endpackage

// File: rtl/isq_step_ctrl.sv
module isq_step_ctrl
  import isq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [KW-1:0] kind_i,
  input  logic          stall_i,
  output seq_step_e     step_o,
  output seq_kind_e     kind_o,
  output logic          advance_o,
  output logic          done_o
);

  seq_step_e step_q, step_n;
  seq_kind_e kind_q, kind_n;
  logic      done_q, done_n;
  logic      step_en, kind_en;
  logic      kind_ok, launch, last_step;

  always_comb begin
    kind_ok   = (kind_i <= KIND_MAX);
    launch    = (step_q == ST_IDLE) && start_i && kind_ok;
    advance_o = (step_q != ST_IDLE) && !stall_i;

    last_step = (step_q == ST_VEC_H) ||
                ((step_q == ST_PULL_H) && (kind_q != K_RTS)) ||
                (step_q == ST_DUMMY);

    step_n  = step_q;
    kind_n  = kind_q;
    kind_en = launch;
    step_en = launch || advance_o;

    case (step_q)
      ST_IDLE: begin
        kind_n = seq_kind_e'(kind_i);
        if (kind_i == K_RTI)      step_n = ST_PULL_P;
        else if (kind_i == K_RTS) step_n = ST_PULL_L;
        else                      step_n = ST_PUSH_H;
      end
      ST_PUSH_H: step_n = ST_PUSH_L;
      ST_PUSH_L: step_n = ST_PUSH_P;
      ST_PUSH_P: step_n = ST_VEC_L;
      ST_VEC_L:  step_n = ST_VEC_H;
      ST_VEC_H:  step_n = ST_IDLE;
      ST_PULL_P: step_n = ST_PULL_L;
      ST_PULL_L: step_n = ST_PULL_H;
      ST_PULL_H: step_n = (kind_q == K_RTS) ? ST_DUMMY : ST_IDLE;
      ST_DUMMY:  step_n = ST_IDLE;
      default:   step_n = ST_IDLE;
    endcase

    done_n = advance_o && last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      kind_q <= K_RST;
      done_q <= 1'b0;
    end else begin
      if (step_en) step_q <= step_n;
      if (kind_en) kind_q <= kind_n;
      done_q <= done_n;
    end
  end

  assign step_o = step_q;
  assign kind_o = kind_q;
  assign done_o = done_q;

endmodule

// File: rtl/isq_irq_track.sv
module isq_irq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_adv_i,
  input  logic irq_line_i,
  input  logic idis_i,
  input  logic nmi_req_i,
  input  logic nmi_take_i,
  output logic irq_pend_o,
  output logic nmi_pend_o
);

  logic hist_q, hist_n;
  logic irq_q, irq_n;
  logic nmi_q, nmi_n;

  always_comb begin
    hist_n = irq_line_i && !idis_i;
    irq_n  = hist_q;
    nmi_n  = nmi_req_i || (nmi_q && !nmi_take_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      if (cyc_adv_i) begin
        hist_q <= hist_n;
        irq_q  <= irq_n;
      end
      nmi_q <= nmi_n;
    end
  end

  assign irq_pend_o = irq_q;
  assign nmi_pend_o = nmi_q;

endmodule

// File: rtl/isq_datapath.sv
module isq_datapath
  import isq_pkg::*;
#(
  parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_step_e     step_i,
  input  seq_kind_e     kind_i,
  input  logic          advance_i,
  input  logic          nmi_pend_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rdata_i,
  output logic          bus_act_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic          idis_o,
  output logic          nmi_take_o,
  output logic [DW-1:0] pull_stat_o,
  output logic          pull_vld_o
);

  localparam int PC_HI = AW - 1;
  localparam int PC_LO = AW - DW;

  logic [DW-1:0] sp_q, sp_n, sp_inc, sp_dec;
  logic [AW-1:0] pc_q, pc_n, pc_inc;
  logic [AW-1:0] vec_q, vec_n;
  logic          idis_q, idis_n;
  logic [DW-1:0] pstat_q;
  logic          pvld_q, pvld_n;
  logic          sp_en, pc_en, vec_en, idis_en, pstat_en;
  logic          is_push, is_pull;
  logic [DW-1:0] stat_push;

  always_comb begin
    sp_inc  = sp_q + 8'd1;
    sp_dec  = sp_q - 8'd1;
    pc_inc  = pc_q + 16'd1;
    is_push = (step_i == ST_PUSH_H) || (step_i == ST_PUSH_L) || (step_i == ST_PUSH_P);
    is_pull = (step_i == ST_PULL_P) || (step_i == ST_PULL_L) || (step_i == ST_PULL_H);

    stat_push          = status_i;
    stat_push[BRK_BIT] = (kind_i == K_BRK);

    bus_act_o = (step_i != ST_IDLE);
    bus_wr_o  = is_push && (kind_i != K_RST);

    if (is_push)                  bus_addr_o = {STK_PAGE, sp_q};
    else if (is_pull)             bus_addr_o = {STK_PAGE, sp_inc};
    else if (step_i == ST_VEC_L)  bus_addr_o = vec_q;
    else if (step_i == ST_VEC_H)  bus_addr_o = vec_q + 16'd1;
    else if (step_i == ST_DUMMY)  bus_addr_o = pc_q;
    else                          bus_addr_o = '0;

    case (step_i)
      ST_PUSH_H: bus_wdata_o = (kind_i == K_BRK) ? pc_inc[PC_HI:PC_LO] : pc_q[PC_HI:PC_LO];
      ST_PUSH_L: bus_wdata_o = pc_q[DW-1:0];
      ST_PUSH_P: bus_wdata_o = stat_push;
      default:   bus_wdata_o = '0;
    endcase
  end

  // vector choice and interrupt-disable update at the status push
  always_comb begin
    case (kind_i)
      K_RST:   vec_n = VEC_RST;
      K_NMI:   vec_n = VEC_NMI;
      K_BRK:   vec_n = nmi_pend_i ? VEC_NMI : VEC_IRQ;
      default: vec_n = VEC_IRQ;
    endcase
    vec_en     = advance_i && (step_i == ST_PUSH_P);
    nmi_take_o = vec_en && ((kind_i == K_NMI) || ((kind_i == K_BRK) && nmi_pend_i));

    idis_en = advance_i && ((step_i == ST_PUSH_P) || (step_i == ST_PULL_P));
    idis_n  = (step_i == ST_PUSH_P) ? 1'b1 : rdata_i[IDIS_BIT];

    pstat_en = advance_i && (step_i == ST_PULL_P);
    pvld_n   = pstat_en;
  end

  always_comb begin
    sp_en = advance_i && (is_push || is_pull);
    sp_n  = is_push ? sp_dec : sp_inc;

    pc_en = 1'b0;
    pc_n  = pc_q;
    case (step_i)
      ST_PUSH_H: begin
        pc_en = advance_i && (kind_i == K_BRK);
        pc_n  = pc_inc;
      end
      ST_VEC_L, ST_PULL_L: begin
        pc_en = advance_i;
        pc_n  = {pc_q[PC_HI:PC_LO], rdata_i};
      end
      ST_VEC_H, ST_PULL_H: begin
        pc_en = advance_i;
        pc_n  = {rdata_i, pc_q[DW-1:0]};
      end
      ST_DUMMY: begin
        pc_en = advance_i;
        pc_n  = pc_inc;
      end
      default: begin
        pc_en = 1'b0;
        pc_n  = pc_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      pc_q    <= '0;
      vec_q   <= VEC_RST;
      idis_q  <= 1'b1;
      pstat_q <= '0;
      pvld_q  <= 1'b0;
    end else begin
      if (sp_en)    sp_q    <= sp_n;
      if (pc_en)    pc_q    <= pc_n;
      if (vec_en)   vec_q   <= vec_n;
      if (idis_en)  idis_q  <= idis_n;
      if (pstat_en) pstat_q <= rdata_i;
      pvld_q <= pvld_n;
    end
  end

  assign pc_o        = pc_q;
  assign sp_o        = sp_q;
  assign idis_o      = idis_q;
  assign pull_stat_o = pstat_q;
  assign pull_vld_o  = pvld_q;

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import isq_pkg::*;
#(
  parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 16'hFFFE,
  parameter int            RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_start_i,
  input  logic [2:0]    seq_kind_i,
  input  logic          hold_i,
  input  logic          irq_line_i,
  input  logic          nmi_req_i,
  input  logic [7:0]    status_i,
  input  logic [7:0]    bus_rdata_i,
  output logic          bus_act_o,
  output logic          bus_wr_o,
  output logic [15:0]   bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  output logic [15:0]   pc_o,
  output logic [7:0]    sp_o,
  output logic          idis_o,
  output logic          irq_pend_o,
  output logic          nmi_pend_o,
  output logic [7:0]    pull_stat_o,
  output logic          pull_vld_o,
  output logic          done_o
);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  seq_step_e step;
  seq_kind_e kind;
  logic      advance, stall, nmi_take;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  assign stall = bus_act_o && !bus_wr_o && hold_i;

  isq_step_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (seq_start_i),
    .kind_i    (seq_kind_i),
    .stall_i   (stall),
    .step_o    (step),
    .kind_o    (kind),
    .advance_o (advance),
    .done_o    (done_o)
  );

  isq_datapath #(
    .VEC_NMI (VEC_NMI),
    .VEC_RST (VEC_RST),
    .VEC_IRQ (VEC_IRQ)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .step_i      (step),
    .kind_i      (kind),
    .advance_i   (advance),
    .nmi_pend_i  (nmi_pend_o),
    .status_i    (status_i),
    .rdata_i     (bus_rdata_i),
    .bus_act_o   (bus_act_o),
    .bus_wr_o    (bus_wr_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .idis_o      (idis_o),
    .nmi_take_o  (nmi_take),
    .pull_stat_o (pull_stat_o),
    .pull_vld_o  (pull_vld_o)
  );

  isq_irq_track u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cyc_adv_i  (!stall),
    .irq_line_i (irq_line_i),
    .idis_i     (idis_o),
    .nmi_req_i  (nmi_req_i),
    .nmi_take_i (nmi_take),
    .irq_pend_o (irq_pend_o),
    .nmi_pend_o (nmi_pend_o)
  );

endmodule

// File: rtl/isq_checker.sv
module isq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_act_o,
  input logic        bus_wr_o,
  input logic [15:0] bus_addr_o,
  input logic [7:0]  sp_o,
  input logic [15:0] pc_o,
  input logic        hold_i,
  input logic        irq_line_i,
  input logic        idis_o,
  input logic        irq_pend_o,
  input logic        done_o
);

  logic [1:0] age_q;
  logic       stall_w;

  assign stall_w = bus_act_o && !bus_wr_o && hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assert_push_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act_o && bus_wr_o) |-> (bus_addr_o == {8'h01, sp_o}));

  assert_push_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act_o && bus_wr_o) |=> (sp_o == $past(sp_o) - 8'd1));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> ($stable(bus_addr_o) && $stable(sp_o) && $stable(pc_o) && bus_act_o));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_act_o);

  assert_irq_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 2'd3) && !$past(stall_w) && !$past(stall_w, 2)) |->
      (irq_pend_o == $past(irq_line_i && !idis_o, 2)));

endmodule

bind irq_stack_seq isq_checker i_isq_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_act_o  (bus_act_o),
  .bus_wr_o   (bus_wr_o),
  .bus_addr_o (bus_addr_o),
  .sp_o       (sp_o),
  .pc_o       (pc_o),
  .hold_i     (hold_i),
  .irq_line_i (irq_line_i),
  .idis_o     (idis_o),
  .irq_pend_o (irq_pend_o),
  .done_o     (done_o)
);

// File: tb/test_irq_stack_seq.sv
module test_irq_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seq_start_i, hold_i, irq_line_i, nmi_req_i;
  logic [2:0]  seq_kind_i;
  logic [7:0]  status_i, bus_rdata_i;
  logic        bus_act_o, bus_wr_o, idis_o, irq_pend_o, nmi_pend_o, pull_vld_o, done_o;
  logic [15:0] bus_addr_o, pc_o;
  logic [7:0]  bus_wdata_o, sp_o, pull_stat_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [7:0] m_sp = 8'h00;
  logic       m_nmi = 1'b0;
  logic [7:0] stk [256];

  always #5 clk = ~clk;

  irq_stack_seq i_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .seq_start_i(seq_start_i), .seq_kind_i(seq_kind_i),
    .hold_i(hold_i), .irq_line_i(irq_line_i), .nmi_req_i(nmi_req_i), .status_i(status_i),
    .bus_rdata_i(bus_rdata_i), .bus_act_o(bus_act_o), .bus_wr_o(bus_wr_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .pc_o(pc_o), .sp_o(sp_o),
    .idis_o(idis_o), .irq_pend_o(irq_pend_o), .nmi_pend_o(nmi_pend_o),
    .pull_stat_o(pull_stat_o), .pull_vld_o(pull_vld_o), .done_o(done_o)
  );

  // bus memory model: stack page array plus fixed vectors
  always_comb begin
    case (bus_addr_o)
      16'hFFFA: bus_rdata_i = 8'h00;
      16'hFFFB: bus_rdata_i = 8'h90;
      16'hFFFC: bus_rdata_i = 8'h00;
      16'hFFFD: bus_rdata_i = 8'h80;
      16'hFFFE: bus_rdata_i = 8'h00;
      16'hFFFF: bus_rdata_i = 8'hA0;
      default:  bus_rdata_i = (bus_addr_o[15:8] == 8'h01) ? stk[bus_addr_o[7:0]]
                                                           : (bus_addr_o[7:0] ^ 8'h5A);
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
      stk[8'hFE] <= 8'h33;
      stk[8'hFF] <= 8'h12;
    end else if (bus_act_o && bus_wr_o) begin
      stk[bus_addr_o[7:0]] <= bus_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  stat;
    logic        nmi;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        idis;
    logic [23:0] aux;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 8'h00, 1'b0, 16'h8000, 8'hFD, 1'b1, 24'h000000},
    '{3'd2, 8'h20, 1'b0, 16'hA000, 8'hFA, 1'b1, 24'h800020},
    '{3'd4, 8'h00, 1'b0, 16'h8000, 8'hFD, 1'b0, 24'h000020},
    '{3'd3, 8'h00, 1'b0, 16'hA000, 8'hFA, 1'b1, 24'h800110},
    '{3'd4, 8'h00, 1'b0, 16'h8001, 8'hFD, 1'b0, 24'h000010},
    '{3'd1, 8'h04, 1'b0, 16'h9000, 8'hFA, 1'b1, 24'h800104},
    '{3'd4, 8'h00, 1'b0, 16'h8001, 8'hFD, 1'b1, 24'h000004},
    '{3'd3, 8'h04, 1'b1, 16'h9000, 8'hFA, 1'b1, 24'h800214},
    '{3'd4, 8'h00, 1'b0, 16'h8002, 8'hFD, 1'b1, 24'h000014},
    '{3'd5, 8'h00, 1'b0, 16'h1234, 8'hFF, 1'b1, 24'h000000},
    '{3'd0, 8'h00, 1'b0, 16'h8000, 8'hFC, 1'b1, 24'h000000}
  };

  // runs one sequence; checks each bus cycle against the expected address/direction
  task automatic run_seq(input logic [2:0] k, input logic [7:0] st, input int hold_n,
                         input bit kick, input logic [15:0] dummy_pc, output int ncyc);
    logic [15:0] ea [5];
    logic        ew [5];
    logic [15:0] vec;
    int nstep, idx, iter;
    bit stalled;
    nstep = 0;
    for (int i = 0; i < 5; i++) begin ea[i] = 16'h0; ew[i] = 1'b0; end
    if (k <= 3'd3) begin
      for (int i = 0; i < 3; i++) begin
        ea[i] = {8'h01, 8'(m_sp - 8'(i))};
        ew[i] = (k != 3'd0);
      end
      case (k)
        3'd0:    vec = 16'hFFFC;
        3'd1:    vec = 16'hFFFA;
        3'd2:    vec = 16'hFFFE;
        default: vec = m_nmi ? 16'hFFFA : 16'hFFFE;
      endcase
      ea[3] = vec; ea[4] = vec + 16'd1;
      nstep = 5;
    end else if (k == 3'd4) begin
      for (int i = 0; i < 3; i++) ea[i] = {8'h01, 8'(m_sp + 8'd1 + 8'(i))};
      nstep = 3;
    end else begin
      for (int i = 0; i < 2; i++) ea[i] = {8'h01, 8'(m_sp + 8'd1 + 8'(i))};
      ea[2] = dummy_pc;
      nstep = 3;
    end
    @(negedge clk);
    status_i = st; seq_kind_i = k; seq_start_i = 1'b1;
    @(negedge clk);
    seq_start_i = 1'b0;
    idx = 0; iter = 0; ncyc = 0;
    while (!done_o && iter < 20) begin
      hold_i = (iter < hold_n);
      if (kick && iter == 1) begin seq_start_i = 1'b1; seq_kind_i = 3'd0; end
      else seq_start_i = 1'b0;
      #1;
      chk(bus_act_o == 1'b1, "R11 bus active during sequence", bus_act_o, 1);
      if (idx < nstep) begin
        chk(bus_addr_o == ea[idx], "R1 R3 R7 bus address", bus_addr_o, ea[idx]);
        chk(bus_wr_o == ew[idx], "R5 bus direction", bus_wr_o, ew[idx]);
      end else begin
        chk(1'b0, "R11 sequence too long", idx, nstep);
      end
      stalled = hold_i && !bus_wr_o;
      if (!stalled) idx++;
      ncyc++; iter++;
      @(negedge clk);
    end
    hold_i = 1'b0; seq_start_i = 1'b0;
    #1;
    chk(done_o == 1'b1, "R11 done pulse", done_o, 1);
    chk(!bus_act_o, "R11 idle at done", bus_act_o, 0);
    chk(idx == nstep, "R11 bus cycle count", idx, nstep);
    @(negedge clk);
    #1;
    chk(!done_o, "R11 done one clock only", done_o, 0);
    chk(!bus_act_o, "R11 no new sequence", bus_act_o, 0);
  endtask

  task automatic check_end(input vec_t v);
    chk(pc_o == v.pc, "R3 R6 R7 program counter", pc_o, v.pc);
    chk(sp_o == v.sp, "R1 R10 stack pointer", sp_o, v.sp);
    chk(idis_o == v.idis, "R3 R6 disable flag", idis_o, v.idis);
    if (v.kind == 3'd1 || v.kind == 3'd2 || v.kind == 3'd3) begin
      chk(stk[8'(v.sp + 8'd3)] == v.aux[23:16], "R2 pushed PC high", stk[8'(v.sp + 8'd3)], v.aux[23:16]);
      chk(stk[8'(v.sp + 8'd2)] == v.aux[15:8],  "R2 pushed PC low",  stk[8'(v.sp + 8'd2)], v.aux[15:8]);
      chk(stk[8'(v.sp + 8'd1)] == v.aux[7:0],   "R2 pushed status",  stk[8'(v.sp + 8'd1)], v.aux[7:0]);
    end
    if (v.kind == 3'd4)
      chk(pull_stat_o == v.aux[7:0], "R6 pulled status", pull_stat_o, v.aux[7:0]);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int nc;
    vec_t v;
    rst_n = 1'b0; seq_start_i = 1'b0; seq_kind_i = 3'd0; hold_i = 1'b0;
    irq_line_i = 1'b0; nmi_req_i = 1'b0; status_i = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk(pc_o == 16'h0, "R12 reset pc", pc_o, 0);
    chk(sp_o == 8'h0, "R12 reset sp", sp_o, 0);
    chk(idis_o == 1'b1, "R12 reset idis", idis_o, 1);
    chk(!bus_act_o && !done_o && !irq_pend_o && !nmi_pend_o, "R12 reset outputs",
        {bus_act_o, done_o, irq_pend_o, nmi_pend_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: entry 0 also covers R10 wrap 0x00 -> 0xFF
    for (int e = 0; e < NV; e++) begin
      v = TBL[e];
      if (v.nmi) begin
        @(negedge clk); nmi_req_i = 1'b1;
        @(negedge clk); nmi_req_i = 1'b0;
        #1;
        chk(nmi_pend_o == 1'b1, "R4 nmi latched", nmi_pend_o, 1);
        m_nmi = 1'b1;
      end
      run_seq(v.kind, v.stat, 0, 1'b0, v.pc - 16'd1, nc);
      check_end(v);
      if (v.nmi) chk(nmi_pend_o == 1'b0, "R4 nmi consumed by break", nmi_pend_o, 0);
      if (v.kind == 3'd1 || v.kind == 3'd3) m_nmi = 1'b0;
      m_sp = v.sp;
    end

    // R8: line raised while disable set is never seen
    irq_line_i = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(irq_pend_o == 1'b0, "R8 masked irq", irq_pend_o, 0);
    irq_line_i = 1'b0;

    // R9: hold over write cycles does not stall
    run_seq(3'd2, 8'h00, 3, 1'b0, 16'h0, nc);
    chk(nc == 5, "R9 writes ignore hold", nc, 5);
    check_end('{3'd2, 8'h00, 1'b0, 16'hA000, 8'hF9, 1'b1, 24'h800000});
    m_sp = 8'hF9;

    // R9: hold over the first read stalls it three clocks
    run_seq(3'd4, 8'h00, 3, 1'b0, 16'h0, nc);
    chk(nc == 6, "R9 read stalled by hold", nc, 6);
    check_end('{3'd4, 8'h00, 1'b0, 16'h8000, 8'hFC, 1'b0, 24'h000000});
    m_sp = 8'hFC;

    // R8: with disable clear, pending follows the line two clocks later
    irq_line_i = 1'b1;
    @(negedge clk); #1;
    chk(irq_pend_o == 1'b0, "R8 irq not yet pending", irq_pend_o, 0);
    @(negedge clk); #1;
    chk(irq_pend_o == 1'b1, "R8 irq pending after two clocks", irq_pend_o, 1);
    irq_line_i = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(irq_pend_o == 1'b0, "R8 irq released", irq_pend_o, 0);

    // R11: start while busy ignored
    run_seq(3'd3, 8'h00, 0, 1'b1, 16'h0, nc);
    check_end('{3'd3, 8'h00, 1'b0, 16'hA000, 8'hF9, 1'b1, 24'h800110});
    m_sp = 8'hF9;

    // R11: unused kind codes ignored
    for (int kk = 6; kk < 8; kk++) begin
      @(negedge clk); seq_kind_i = 3'(kk); seq_start_i = 1'b1;
      @(negedge clk); seq_start_i = 1'b0;
      #1;
      chk(!bus_act_o, "R11 unused kind ignored", bus_act_o, 0);
      @(negedge clk); #1;
      chk(!bus_act_o && sp_o == 8'hF9, "R11 unused kind no effect", sp_o, 8'hF9);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule